// File: doc/BRIEF.md
# Remote Terminal Status Word Register

This block keeps the 16-bit status word that a serial-bus remote terminal sends back after each command. The host raises service request, busy, subsystem flag, terminal flag and dynamic-bus-control acceptance through active-low inputs. These inputs pass through a synchronizer, and they reach the word only when the protocol sequencer pulses a status update. The sequencer also reports the error events, which set the message error bit: format or word faults in the received message, and an illegal-command marking from the host.

Besides the register, the block handles three things near the host. It holds back host data requests for transmit commands while the busy bit is set. It presents the status word on the parallel data bus inside a timed enable window that contains a strobe. It also issues the good-block-received pulse when a plain receive command completes cleanly.

Top module: `rt_status_reg`

## Requirements
- R1: After reset, status word bits 10..0 are zero, bits 15..11 follow `term_addr`, and `msg_err_n`, `stat_en_n`, `strobe_n` and `gbr_n` are high.
- R2: The active-low host inputs pass through SYNC_STAGES flops. On a `status_upd` pulse each one sets its bit when low and clears it when high: service request in bit 8, busy in bit 3, subsystem flag in bit 2 and terminal flag in bit 0. Bits 9 and 7..5 always read zero.
- R3: Between update pulses, status bits 9..0 other than bit 10 hold their values, whatever the host inputs do.
- R4: At an update, bit 1 (dynamic bus control accepted) is set only when the synchronized accept input is low, `cmd_dbc` is high and the current command has not been marked illegal.
- R5: At an update, bit 4 (broadcast received) takes the value of `cmd_bcast`.
- R6: The synchronized `illcmd_n` is sampled only at the clock where `in_cmd` rises. If it is low there, bit 10 is set from the next cycle. Changes of `illcmd_n` at other times have no effect, and the illegal marking never drives `msg_err_n` low.
- R7: A `fmt_err` pulse drives `msg_err_n` low and sets bit 10 from the next cycle. Both stay set until a `new_grant` pulse clears them together with the illegal marking. A set in the same cycle as `new_grant` wins.
- R8: `host_req_n` is low exactly when `data_need` is high, unless bit 3 (busy) is set and `cmd_tx` is high.
- R9: A `stat_go` pulse holds `stat_en_n` low for STAT_WIN cycles, and `bus_data` shows the status word during that window and zero outside it. `strobe_n` is low for STB_LEN cycles starting STB_OFS cycles into the window. A `stat_go` that arrives during a window is ignored.
- R10: `rx_done` produces a GBR_LEN-cycle low pulse on `gbr_n` only if `cmd_tx` and `cmd_mode` are low, `wc_ok` is high, bit 10 is clear and `fmt_err` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| term_addr | input | 5 | Assigned terminal address |
| srq_n | input | 1 | Host service request, active low |
| busy_n | input | 1 | Host busy, active low |
| ssflag_n | input | 1 | Subsystem flag, active low |
| rtflag_n | input | 1 | Terminal flag, active low |
| dbc_acc_n | input | 1 | Accept dynamic bus control, active low |
| illcmd_n | input | 1 | Host marks command illegal, active low |
| in_cmd | input | 1 | Command in service |
| new_grant | input | 1 | Start of new message pulse |
| fmt_err | input | 1 | Format or word error pulse |
| status_upd | input | 1 | Status capture pulse |
| cmd_dbc | input | 1 | Command is a valid dynamic-bus-control mode command |
| cmd_bcast | input | 1 | Command was broadcast |
| cmd_tx | input | 1 | Command is transmit |
| cmd_mode | input | 1 | Command is a mode command |
| data_need | input | 1 | Sequencer needs a host transfer |
| rx_done | input | 1 | Receive message finished pulse |
| wc_ok | input | 1 | Word count matched |
| stat_go | input | 1 | Start status presentation |
| status_word | output | 16 | Current status word |
| msg_err_n | output | 1 | Message error flag, active low |
| host_req_n | output | 1 | Host data request, active low |
| stat_en_n | output | 1 | Status on parallel bus, active low |
| strobe_n | output | 1 | Data strobe, active low |
| bus_data | output | 16 | Parallel bus data |
| gbr_n | output | 1 | Good block received pulse, active low |

## Verification
The bench builds the block with SYNC_STAGES=2, STAT_WIN=6, STB_OFS=2, STB_LEN=2 and GBR_LEN=6. With these values the strobe sits strictly inside the enable window, with idle cycles before and after it. The retrigger test can therefore land a second `stat_go` in the middle of a window and show that it is ignored. The two-stage synchronizer gives a fixed three-cycle delay from input to capture. The bench uses that delay to prove both capture at the update and hold between updates.

// File: rtl/rt_status_reg.sv
module rt_status_reg #(
  parameter int SYNC_STAGES = 2,
  parameter int STAT_WIN    = 6,
  parameter int STB_OFS     = 2,
  parameter int STB_LEN     = 2,
  parameter int GBR_LEN     = 6
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [4:0]  term_addr,
  input  logic        srq_n,
  input  logic        busy_n,
  input  logic        ssflag_n,
  input  logic        rtflag_n,
  input  logic        dbc_acc_n,
  input  logic        illcmd_n,
  input  logic        in_cmd,
  input  logic        new_grant,
  input  logic        fmt_err,
  input  logic        status_upd,
  input  logic        cmd_dbc,
  input  logic        cmd_bcast,
  input  logic        cmd_tx,
  input  logic        cmd_mode,
  input  logic        data_need,
  input  logic        rx_done,
  input  logic        wc_ok,
  input  logic        stat_go,
  output logic [15:0] status_word,
  output logic        msg_err_n,
  output logic        host_req_n,
  output logic        stat_en_n,
  output logic        strobe_n,
  output logic [15:0] bus_data,
  output logic        gbr_n
);
  localparam int CW = $clog2(STAT_WIN + 1);
  localparam int GW = $clog2(GBR_LEN + 1);
  localparam logic [CW-1:0] WIN_V = CW'(STAT_WIN);
  localparam logic [CW-1:0] OFS_V = CW'(STB_OFS);
  localparam logic [CW-1:0] END_V = CW'(STB_OFS + STB_LEN);
  localparam logic [CW-1:0] ONE_C = CW'(1);
  localparam logic [GW-1:0] GLEN_V = GW'(GBR_LEN);
  localparam logic [GW-1:0] GONE_C = GW'(1);

  // synchronizer: {ill, dbc, rtf, ssf, busy, srq}
  logic [5:0] sync_q [SYNC_STAGES];
  logic [5:0] s_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < SYNC_STAGES; i++) sync_q[i] <= '1;
    end else begin
      sync_q[0] <= {illcmd_n, dbc_acc_n, rtflag_n, ssflag_n, busy_n, srq_n};
      for (int i = 1; i < SYNC_STAGES; i++) sync_q[i] <= sync_q[i-1];
    end
  end
  assign s_n = sync_q[SYNC_STAGES-1];

  logic in_cmd_d, cmd_rise;
  logic ill_q, me_q, fe_q;
  logic ill_hit;
  assign cmd_rise = in_cmd & ~in_cmd_d;
  assign ill_hit  = cmd_rise & ~s_n[5];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_cmd_d <= 1'b0;
      ill_q    <= 1'b0;
      me_q     <= 1'b0;
      fe_q     <= 1'b0;
    end else begin
      in_cmd_d <= in_cmd;
      if (cmd_rise)       ill_q <= ~s_n[5];
      else if (new_grant) ill_q <= 1'b0;
      if (fmt_err | ill_hit) me_q <= 1'b1;
      else if (new_grant)    me_q <= 1'b0;
      if (fmt_err)        fe_q <= 1'b1;
      else if (new_grant) fe_q <= 1'b0;
    end
  end

  // captured flags: {srq, bcast, busy, ssf, dbca, tf}
  logic srq_q, bc_q, busy_q, ssf_q, dbca_q, tf_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {srq_q, bc_q, busy_q, ssf_q, dbca_q, tf_q} <= '0;
    end else if (status_upd) begin
      srq_q  <= ~s_n[0];
      busy_q <= ~s_n[1];
      ssf_q  <= ~s_n[2];
      tf_q   <= ~s_n[3];
      dbca_q <= ~s_n[4] & cmd_dbc & ~ill_q;
      bc_q   <= cmd_bcast;
    end
  end

  assign status_word = {term_addr, me_q, 1'b0, srq_q, 3'b000,
                        bc_q, busy_q, ssf_q, dbca_q, tf_q};
  assign msg_err_n   = ~fe_q;
  assign host_req_n  = ~(data_need & ~(busy_q & cmd_tx));

  // status presentation window
  logic [CW-1:0] win_cnt, phase;
  logic          win_on;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    win_cnt <= '0;
    else if (win_cnt != '0)        win_cnt <= win_cnt - ONE_C;
    else if (stat_go)              win_cnt <= WIN_V;
  end
  assign win_on    = (win_cnt != '0);
  assign phase     = WIN_V - win_cnt;
  assign stat_en_n = ~win_on;
  assign strobe_n  = ~(win_on && phase >= OFS_V && phase < END_V);
  assign bus_data  = win_on ? status_word : '0;

  // good block received
  logic [GW-1:0] gbr_cnt;
  logic          gbr_ok;
  assign gbr_ok = rx_done & ~cmd_tx & ~cmd_mode & wc_ok & ~me_q & ~fmt_err;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              gbr_cnt <= '0;
    else if (gbr_ok)         gbr_cnt <= GLEN_V;
    else if (gbr_cnt != '0)  gbr_cnt <= gbr_cnt - GONE_C;
  end
  assign gbr_n = (gbr_cnt == '0);

  a_r7_err_sets: assert property (@(posedge clk) disable iff (!rst_n)
    fmt_err |=> !msg_err_n);
  a_r7_err_clears: assert property (@(posedge clk) disable iff (!rst_n)
    new_grant && !fmt_err |=> msg_err_n);
  a_r6_ill_not_on_flag: assert property (@(posedge clk) disable iff (!rst_n)
    msg_err_n && !fmt_err |=> msg_err_n);
  a_r3_flags_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !status_upd |=> $stable(status_word[9:0] & 10'h1FF));
  a_r8_busy_blocks_tx: assert property (@(posedge clk) disable iff (!rst_n)
    status_word[3] && cmd_tx |-> host_req_n);
  a_r9_strobe_in_window: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe_n |-> !stat_en_n);
  a_r10_no_gbr_bad_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    gbr_n && rx_done && (cmd_tx || cmd_mode || !wc_ok) |=> gbr_n);
endmodule

// File: tb/test_rt_status_reg.sv
module test_rt_status_reg;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [4:0] term_addr = 5'b10101;
  logic srq_n = 1, busy_n = 1, ssflag_n = 1, rtflag_n = 1, dbc_acc_n = 1, illcmd_n = 1;
  logic in_cmd = 0, new_grant = 0, fmt_err = 0, status_upd = 0, cmd_dbc = 0, cmd_bcast = 0;
  logic cmd_tx = 0, cmd_mode = 0, data_need = 0, rx_done = 0, wc_ok = 0, stat_go = 0;
  logic [15:0] status_word, bus_data;
  logic msg_err_n, host_req_n, stat_en_n, strobe_n, gbr_n;
  int n_cmp = 0, n_bad = 0;

  always #4 clk = ~clk;

  rt_status_reg i_rt_status_reg (.*);

  // {srq_n,busy_n,ssf_n,rtf_n,dbc_n,cmd_dbc,bcast} , expected bits 8..0
  localparam logic [15:0] VEC [7] = '{
    {7'b1111100, 9'h000},
    {7'b0111100, 9'h100},
    {7'b1011101, 9'h018},
    {7'b1100100, 9'h005},
    {7'b1111010, 9'h002},
    {7'b1111000, 9'h000},
    {7'b0000011, 9'h11F}
  };

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic settle(); repeat (3) @(negedge clk); endtask
  task automatic pulse_upd();
    status_upd = 1; @(negedge clk); status_upd = 0;
  endtask
  task automatic pulse_grant();
    new_grant = 1; @(negedge clk); new_grant = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    int en_cnt, st_cnt, st_first, gl;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 word", status_word, 16'hA800);
    chk("R1 outs", {12'd0, msg_err_n, stat_en_n, strobe_n, gbr_n}, 16'h000F);

    // R2 R4 R5 vector walk
    for (int i = 0; i < 7; i++) begin
      {srq_n, busy_n, ssflag_n, rtflag_n, dbc_acc_n, cmd_dbc, cmd_bcast} = VEC[i][15:9];
      settle();
      pulse_upd();
      chk($sformatf("R2 R4 R5 vec%0d", i), status_word, {5'b10101, 2'b00, VEC[i][8:0]});
    end

    // R3 hold between updates
    {srq_n, busy_n, ssflag_n, rtflag_n, dbc_acc_n, cmd_dbc, cmd_bcast} = 7'b1111100;
    repeat (6) @(negedge clk);
    chk("R3 hold", status_word, 16'hA91F);

    // R8 busy gating
    data_need = 1; cmd_tx = 1; #1;
    chk("R8 busy tx", {15'd0, host_req_n}, 16'h1);
    cmd_tx = 0; #1;
    chk("R8 busy rx", {15'd0, host_req_n}, 16'h0);
    pulse_upd();
    cmd_tx = 1; #1;
    chk("R8 idle tx", {15'd0, host_req_n}, 16'h0);
    data_need = 0; cmd_tx = 0; #1;
    chk("R8 no need", {15'd0, host_req_n}, 16'h1);
    chk("R2 cleared", status_word, 16'hA800);

    // R6 R4 illegal command
    illcmd_n = 0; dbc_acc_n = 0; cmd_dbc = 1;
    settle();
    in_cmd = 1; @(negedge clk);
    chk("R6 me bit", status_word & 16'h0400, 16'h0400);
    chk("R6 flag untouched", {15'd0, msg_err_n}, 16'h1);
    pulse_upd();
    chk("R4 illegal blocks dbca", status_word & 16'h0002, 16'h0000);
    in_cmd = 0; illcmd_n = 1;
    pulse_grant();
    chk("R6 grant clears", status_word & 16'h0400, 16'h0000);
    settle();
    in_cmd = 1; @(negedge clk);
    illcmd_n = 0;
    repeat (4) @(negedge clk);
    chk("R6 late ignored", status_word & 16'h0400, 16'h0000);
    pulse_upd();
    chk("R4 dbca legal", status_word & 16'h0002, 16'h0002);
    in_cmd = 0; illcmd_n = 1; dbc_acc_n = 1; cmd_dbc = 0;
    settle(); pulse_upd();

    // R7 format error
    fmt_err = 1; @(negedge clk); fmt_err = 0;
    chk("R7 flag low", {15'd0, msg_err_n}, 16'h0);
    chk("R7 me bit", status_word & 16'h0400, 16'h0400);
    repeat (5) @(negedge clk);
    chk("R7 held", {15'd0, msg_err_n}, 16'h0);
    pulse_grant();
    chk("R7 cleared", {15'd0, msg_err_n}, 16'h1);
    fmt_err = 1; new_grant = 1; @(negedge clk); fmt_err = 0; new_grant = 0;
    chk("R7 set wins", {15'd0, msg_err_n}, 16'h0);
    pulse_grant();
    chk("R7 clear again", {msg_err_n, 15'd0} | (status_word & 16'h0400), 16'h8000);

    // R9 status window with retrigger
    srq_n = 0; busy_n = 0; settle(); pulse_upd();
    srq_n = 1; busy_n = 1;
    en_cnt = 0; st_cnt = 0; st_first = -1;
    stat_go = 1;
    for (int i = 0; i < 9; i++) begin
      @(negedge clk);
      stat_go = (i == 2);
      if (!stat_en_n) begin
        en_cnt++;
        chk("R9 bus word", bus_data, 16'hA908);
      end else chk("R9 bus idle", bus_data, 16'h0000);
      if (!strobe_n) begin
        st_cnt++;
        if (st_first < 0) st_first = i;
      end
    end
    chk("R9 window len", 16'(en_cnt), 16'd6);
    chk("R9 strobe len", 16'(st_cnt), 16'd2);
    chk("R9 strobe pos", 16'(st_first), 16'd2);

    // R10 good block received
    for (int k = 0; k < 5; k++) begin
      cmd_tx = (k == 3); cmd_mode = (k == 2); wc_ok = (k != 1);
      if (k == 4) begin fmt_err = 1; @(negedge clk); fmt_err = 0; end
      rx_done = 1; @(negedge clk); rx_done = 0;
      gl = 0;
      for (int j = 0; j < 10; j++) begin
        if (!gbr_n) gl++;
        @(negedge clk);
      end
      chk($sformatf("R10 case%0d", k), 16'(gl), (k == 0) ? 16'd6 : 16'd0);
      cmd_tx = 0; cmd_mode = 0; wc_ok = 0;
    end
    pulse_grant();

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule